// File: doc/BRIEF.md
# DDR Column-Command Latency Scheduler

This block sits in a DDR SDRAM controller next to the command issue logic. Column commands may be posted ahead of time with an additive latency. When the controller issues a READ or WRITE, the block works out the cycle in which read data comes back and the cycles in which write data and the write strobe must be driven. It then opens a burst window covering those cycles. Data moves on both clock edges, so a burst of 4 beats takes two clock cycles and a burst of 8 beats takes four. Each output cycle carries two beats, and the block reports the column offset of each beat in the burst order that is configured.

Reads and writes each travel down their own tag delay line. The line is deep enough for the largest read latency, so commands that overlap in flight keep their own timing. Reads issued back to back, or writes issued back to back, at the burst spacing give enables with no gaps. The latency configuration is held in registers. A new configuration is accepted only while the pipelines are empty.

Top module: `ddr_lat_pipe`

## Requirements
- R1: After reset every output is low, and the configuration is column latency 3, additive latency 0, 4-beat bursts, sequential order.
- R2: A read is issued by cmd_valid=1 with cmd_write=0 at a clock edge. Read latency RL equals additive plus column latency. rd_cap_en goes high in the cycle after the edge that lies RL edges after the issue edge, and it stays high for one burst window.
- R3: A write has latency WL = RL-1. wr_data_en goes high after the edge that lies WL edges after the issue edge, and it stays high for one burst window.
- R4: wr_dqs_en goes high one cycle before the first wr_data_en cycle. It stays high through the last wr_data_en cycle and falls together with it.
- R5: The burst window lasts 4 cycles when cfg_bl8=1 (8 beats) and 2 cycles when cfg_bl8=0 (4 beats).
- R6: In window cycle k, beat_lo reports beat 2k and beat_hi reports beat 2k+1. For start column s and beat n, the low two bits of the beat index are (s+n) mod 4 in sequential order and s XOR n in interleaved order (cfg_intl=1). Bit 2 is s[2] XOR n[2] for 8-beat bursts and 0 for 4-beat bursts.
- R7: Two reads, or two writes, issued a burst window apart produce one continuous enable with no gap. A read and a write that overlap in flight are each timed independently.
- R8: cfg_load takes effect only at an edge where no command is issued and none is in flight. A load at any other edge is ignored.
- R9: A cfg_load with column latency outside 3..5 or additive latency above 4 is ignored.
- R10: While rd_cap_en is high, beat_lo and beat_hi come from the read burst. Otherwise, while wr_data_en is high, they come from the write burst. When neither is high, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command issue pulse |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | 3 | Starting column offset within the burst |
| cfg_load | input | 1 | Request to load the latency configuration |
| cfg_cl | input | 3 | Column latency in clocks (3..5) |
| cfg_al | input | 3 | Additive latency in clocks (0..4) |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts, 0 = 4-beat bursts |
| cfg_intl | input | 1 | 1 = interleaved order, 0 = sequential order |
| rd_cap_en | output | 1 | Read data capture window |
| wr_data_en | output | 1 | Write data drive window |
| wr_dqs_en | output | 1 | Write strobe drive window, including the preamble |
| beat_lo | output | 3 | Column offset of the first beat in this cycle |
| beat_hi | output | 3 | Column offset of the second beat in this cycle |

## Verification
A vector table sweeps single reads and single writes over the two ends of the latency range and several values in between. It also crosses both burst lengths with both orders and with start columns that have bit 2 set and cleared. This separates errors in the latency sum, in the one-cycle write offset, in the window length and in the beat formula. Directed sequences then issue paired commands. Two reads or two writes at burst spacing expose gaps or truncation when a window reloads. A read followed one cycle later by a write lands both windows on the same cycles, which exposes shared-pipeline collisions and the beat priority. Configuration loads made during a burst, and loads with illegal values, are then followed by a clean read whose timing shows whether the old settings survived.

// File: rtl/ddr_lat_pkg.sv
package ddr_lat_pkg;
  localparam logic [2:0] CL_MIN = 3'd3;
  localparam logic [2:0] CL_MAX = 3'd5;
  localparam logic [2:0] AL_MAX = 3'd4;
  localparam int COL_W = 3;
  localparam int LAT_W = 4;
  localparam int DLY_DEPTH = int'(CL_MAX) + int'(AL_MAX);

  typedef struct packed {
    logic             vld;
    logic [COL_W-1:0] col;
  } slot_t;

  function automatic logic [LAT_W-1:0] rd_latency(input logic [2:0] al, input logic [2:0] cl);
    return {1'b0, al} + {1'b0, cl};
  endfunction

  function automatic logic cfg_legal(input logic [2:0] cl, input logic [2:0] al);
    return (cl >= CL_MIN) && (cl <= CL_MAX) && (al <= AL_MAX);
  endfunction

  // column offset of beat n for start column s
  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] s,
                                                input logic [COL_W-1:0] n,
                                                input logic bl8, input logic intl);
    logic [1:0] lo;
    lo = intl ? (s[1:0] ^ n[1:0]) : (s[1:0] + n[1:0]);
    return {bl8 & (s[2] ^ n[2]), lo};
  endfunction
endpackage

// File: rtl/ddr_lat_delay.sv
module ddr_lat_delay
  import ddr_lat_pkg::*;
#(
  parameter int DEPTH = DLY_DEPTH,
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [POS_W-1:0] ins_pos,
  input  logic [COL_W-1:0] ins_col,
  output slot_t            head,
  output logic             busy
);
  slot_t      sr [DEPTH];
  logic [DEPTH-1:0] vld_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    slot_t nxt;
    always_comb begin
      if (ins && ins_pos == POS_W'(i)) nxt = '{vld: 1'b1, col: ins_col};
      else if (i < DEPTH - 1)          nxt = sr[(i < DEPTH - 1) ? i + 1 : i];
      else                             nxt = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) sr[i] <= '0;
      else        sr[i] <= nxt;
    end
    assign vld_vec[i] = sr[i].vld;
  end

  assign head = sr[0];
  assign busy = |vld_vec;
endmodule

// File: rtl/ddr_burst_eng.sv
module ddr_burst_eng
  import ddr_lat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             bl8,
  input  logic             intl,
  output logic             active,
  output logic [COL_W-1:0] beat_lo,
  output logic [COL_W-1:0] beat_hi
);
  logic [1:0]       cyc;
  logic [COL_W-1:0] col;
  logic [1:0]       last_cyc;

  assign last_cyc = bl8 ? 2'd3 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      col    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cyc    <= '0;
      col    <= start_col;
    end else if (active) begin
      if (cyc == last_cyc) active <= 1'b0;
      else                 cyc    <= cyc + 2'd1;
    end
  end

  assign beat_lo = active ? beat_col(col, {cyc, 1'b0}, bl8, intl) : '0;
  assign beat_hi = active ? beat_col(col, {cyc, 1'b1}, bl8, intl) : '0;
endmodule

// File: rtl/ddr_lat_pipe.sv
module ddr_lat_pipe
  import ddr_lat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_write,
  input  logic [2:0] cmd_col,
  input  logic       cfg_load,
  input  logic [2:0] cfg_cl,
  input  logic [2:0] cfg_al,
  input  logic       cfg_bl8,
  input  logic       cfg_intl,
  output logic       rd_cap_en,
  output logic       wr_data_en,
  output logic       wr_dqs_en,
  output logic [2:0] beat_lo,
  output logic [2:0] beat_hi
);
  localparam int POS_W = $clog2(DLY_DEPTH);

  logic [2:0]       cl_q, al_q;
  logic             bl8_q, intl_q;
  logic [LAT_W-1:0] rl;
  logic [POS_W-1:0] rd_pos, wr_pos;
  slot_t            rd_head, wr_head;
  logic             rd_busy, wr_busy, rd_act, wr_act;
  logic             rd_start, wr_start, in_flight, cfg_apply;
  logic [2:0]       rd_lo, rd_hi, wr_lo, wr_hi;

  assign rl     = rd_latency(al_q, cl_q);
  assign rd_pos = POS_W'(rl - LAT_W'(1));
  assign wr_pos = POS_W'(rl - LAT_W'(2));

  assign in_flight = cmd_valid | rd_busy | wr_busy | rd_act | wr_act;
  assign cfg_apply = cfg_load & ~in_flight & cfg_legal(cfg_cl, cfg_al);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q   <= CL_MIN;
      al_q   <= '0;
      bl8_q  <= 1'b0;
      intl_q <= 1'b0;
    end else if (cfg_apply) begin
      cl_q   <= cfg_cl;
      al_q   <= cfg_al;
      bl8_q  <= cfg_bl8;
      intl_q <= cfg_intl;
    end
  end

  ddr_lat_delay #(.DEPTH(DLY_DEPTH)) u_rd_dly (
    .clk(clk), .rst_n(rst_n), .ins(cmd_valid & ~cmd_write), .ins_pos(rd_pos),
    .ins_col(cmd_col), .head(rd_head), .busy(rd_busy));

  ddr_lat_delay #(.DEPTH(DLY_DEPTH)) u_wr_dly (
    .clk(clk), .rst_n(rst_n), .ins(cmd_valid & cmd_write), .ins_pos(wr_pos),
    .ins_col(cmd_col), .head(wr_head), .busy(wr_busy));

  assign rd_start = rd_head.vld;
  assign wr_start = wr_head.vld;

  ddr_burst_eng u_rd_eng (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .start_col(rd_head.col),
    .bl8(bl8_q), .intl(intl_q), .active(rd_act), .beat_lo(rd_lo), .beat_hi(rd_hi));

  ddr_burst_eng u_wr_eng (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .start_col(wr_head.col),
    .bl8(bl8_q), .intl(intl_q), .active(wr_act), .beat_lo(wr_lo), .beat_hi(wr_hi));

  assign rd_cap_en  = rd_act;
  assign wr_data_en = wr_act;
  assign wr_dqs_en  = wr_act | wr_start;
  assign beat_lo    = rd_act ? rd_lo : wr_lo;
  assign beat_hi    = rd_act ? rd_hi : wr_hi;
endmodule

// File: rtl/ddr_lat_pipe_chk.sv
module ddr_lat_pipe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_cap_en,
  input logic       wr_data_en,
  input logic       wr_dqs_en,
  input logic [2:0] beat_lo,
  input logic [2:0] beat_hi,
  input logic       in_flight,
  input logic [2:0] cl_q,
  input logic [2:0] al_q,
  input logic       bl8_q,
  input logic       intl_q
);
  AST_STROBE_COVERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |-> wr_dqs_en); // R4
  AST_STROBE_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_en && !$past(wr_data_en)) |-> $past(wr_dqs_en)); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |=> $stable({cl_q, al_q, bl8_q, intl_q})); // R8
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q >= 3'd3) && (cl_q <= 3'd5) && (al_q <= 3'd4)); // R9
  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap_en || wr_data_en) |-> (beat_lo[0] != beat_hi[0])); // R6
  AST_BL4_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_cap_en || wr_data_en) && !bl8_q) |-> (!beat_lo[2] && !beat_hi[2])); // R6
  AST_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cap_en || wr_data_en) |-> (beat_lo == 3'd0 && beat_hi == 3'd0)); // R10
endmodule

bind ddr_lat_pipe ddr_lat_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cap_en(rd_cap_en), .wr_data_en(wr_data_en),
  .wr_dqs_en(wr_dqs_en), .beat_lo(beat_lo), .beat_hi(beat_hi),
  .in_flight(in_flight), .cl_q(cl_q), .al_q(al_q), .bl8_q(bl8_q), .intl_q(intl_q));

// File: tb/ddr_lat_pipe_test.sv
module ddr_lat_pipe_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [2:0] cmd_col = '0;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
  logic cfg_bl8 = 1'b0, cfg_intl = 1'b0;
  logic rd_cap_en, wr_data_en, wr_dqs_en;
  logic [2:0] beat_lo, beat_hi;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cl = 3, m_al = 0;
  bit m_bl8 = 0, m_intl = 0;

  always #5 clk = ~clk;

  ddr_lat_pipe uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cfg_load(cfg_load), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cfg_intl(cfg_intl), .rd_cap_en(rd_cap_en),
    .wr_data_en(wr_data_en), .wr_dqs_en(wr_dqs_en), .beat_lo(beat_lo), .beat_hi(beat_hi));

  // {cl, al, bl8, intl, write, col}
  localparam logic [11:0] VEC [8] = '{
    {3'd3, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1},
    {3'd3, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2},
    {3'd4, 3'd2, 1'b1, 1'b0, 1'b0, 3'd5},
    {3'd5, 3'd4, 1'b1, 1'b1, 1'b1, 3'd3},
    {3'd5, 3'd1, 1'b0, 1'b1, 1'b0, 3'd6},
    {3'd4, 3'd0, 1'b1, 1'b1, 1'b0, 3'd7},
    {3'd3, 3'd3, 1'b1, 1'b0, 1'b1, 3'd4},
    {3'd4, 3'd4, 1'b0, 1'b0, 1'b1, 3'd0}
  };

  function automatic int order(int s, int n, bit bl8, bit intl);
    int low, up;
    if (intl) low = (s % 4) ^ (n % 4);
    else      low = ((s % 4) + (n % 4)) % 4;
    up = bl8 ? ((s / 4 + n / 4) % 2) : 0;
    return up * 4 + low;
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual rd/wr/dqs/lo/hi=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_cfg(int cl, int al, bit bl8, bit intl, bit expect_taken);
    @(negedge clk);
    cfg_load = 1'b1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = bl8; cfg_intl = intl;
    @(negedge clk);
    cfg_load = 1'b0;
    if (expect_taken) begin m_cl = cl; m_al = al; m_bl8 = bl8; m_intl = intl; end
  endtask

  // Issue command A, optionally B at offset b_off; compare every cycle against the model
  task automatic run_window(bit a_wr, int a_col, bit b_en, int b_off, bit b_wr, int b_col, string tag);
    int rl, wl, half;
    rl = m_al + m_cl; wl = rl - 1; half = m_bl8 ? 4 : 2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = a_wr; cmd_col = 3'(a_col);
    for (int m = 0; m < 24; m++) begin
      logic er, ew, eq;
      logic [2:0] rlo, rhi, wlo, whi;
      @(negedge clk);
      er = 0; ew = 0; eq = 0; rlo = 0; rhi = 0; wlo = 0; whi = 0;
      for (int c = 0; c < 2; c++) begin
        bit wr; int o, col, k;
        if (c == 1 && !b_en) continue;
        wr = (c == 0) ? a_wr : b_wr;
        o = (c == 0) ? 0 : b_off;
        col = (c == 0) ? a_col : b_col;
        k = m - o - (wr ? wl : rl);
        if (k >= 0 && k < half) begin
          if (wr) begin ew = 1; wlo = 3'(order(col, 2*k, m_bl8, m_intl)); whi = 3'(order(col, 2*k+1, m_bl8, m_intl)); end
          else    begin er = 1; rlo = 3'(order(col, 2*k, m_bl8, m_intl)); rhi = 3'(order(col, 2*k+1, m_bl8, m_intl)); end
        end
        if (wr && k >= -1 && k < half) eq = 1;
      end
      check(tag, {rd_cap_en, wr_data_en, wr_dqs_en, beat_lo, beat_hi},
            {er, ew, eq, er ? rlo : wlo, er ? rhi : whi});
      cmd_valid = (b_en && m == b_off - 1);
      cmd_write = b_wr; cmd_col = 3'(b_col);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle while and after reset
    check("R1 in reset", {rd_cap_en, wr_data_en, wr_dqs_en, beat_lo, beat_hi}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {rd_cap_en, wr_data_en, wr_dqs_en, beat_lo, beat_hi}, 9'd0);
    // R1: default configuration gives RL 3, 4 beats, sequential
    run_window(1'b0, 3, 1'b0, 0, 1'b0, 0, "R1 default read");
    run_window(1'b1, 1, 1'b0, 0, 1'b0, 0, "R1 default write");

    // table sweep: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      v = VEC[i];
      do_cfg(int'(v[11:9]), int'(v[8:6]), v[5], v[4], 1'b1);
      run_window(v[3], int'(v[2:0]), 1'b0, 0, 1'b0, 0,
                 v[3] ? "R3 R4 R5 R6 write vector" : "R2 R5 R6 read vector");
    end

    // R7: seamless reads and writes, and overlapping read/write (R10 priority)
    do_cfg(4, 1, 1'b1, 1'b0, 1'b1);
    run_window(1'b0, 2, 1'b1, 4, 1'b0, 5, "R7 seamless reads");
    run_window(1'b1, 6, 1'b1, 4, 1'b1, 1, "R7 seamless writes");
    do_cfg(3, 0, 1'b0, 1'b1, 1'b1);
    run_window(1'b0, 1, 1'b1, 2, 1'b0, 2, "R7 seamless reads BL4");
    run_window(1'b0, 3, 1'b1, 1, 1'b1, 6, "R7 R10 read then write overlap");
    run_window(1'b1, 0, 1'b1, 1, 1'b0, 2, "R10 write then read");

    // R8: load during a burst and alongside a command are ignored
    do_cfg(3, 0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 3'd0;
    cfg_load = 1'b1; cfg_cl = 3'd5; cfg_al = 3'd4; cfg_bl8 = 1'b1; cfg_intl = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
    repeat (20) @(negedge clk);
    run_window(1'b0, 1, 1'b0, 0, 1'b0, 0, "R8 mid-burst load ignored");

    // R9: illegal values are ignored
    do_cfg(6, 0, 1'b1, 1'b0, 1'b0);
    run_window(1'b0, 2, 1'b0, 0, 1'b0, 0, "R9 CL6 ignored");
    do_cfg(4, 5, 1'b1, 1'b0, 1'b0);
    run_window(1'b1, 2, 1'b0, 0, 1'b0, 0, "R9 AL5 ignored");
    do_cfg(2, 0, 1'b0, 1'b1, 1'b0);
    run_window(1'b0, 5, 1'b0, 0, 1'b0, 0, "R9 CL2 ignored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule